// File: doc/BRIEF.md
# Multi-Channel Capture Trigger Controller

This block runs one acquisition over a 16-channel sampled input bus. A sample strobe marks each cycle that carries a fresh sample. Each channel has a condition code: don't care, rising edge, falling edge, high or low. After a start pulse the controller captures at once if no channel carries a condition. Otherwise it waits, armed, for the first strobed sample in which every channel condition holds.

From the first stored sample on, a store-enable output marks each sample that belongs to the capture, which a downstream storage path uses as its write enable. When the programmed sample depth has been stored, the controller returns to idle and raises a done flag so the buffer can be read out. A stop pulse cancels the run at any point and marks the result as aborted. A configuration with more than one edge condition is flagged as an error and does not arm the controller.

Top module: `capture_trigger_ctrl`

## Requirements
- R1: After reset, armed, capturing, done, aborted and store_en are all low.
- R2: Each channel i takes a 3-bit code at cond_cfg[3*i+2:3*i]: 0 = don't care, 1 = rising edge, 2 = falling edge, 3 = high level, 4 = low level. Codes 5 to 7 count as don't care. Level conditions are tested on the current strobed sample.
- R3: An edge condition compares the current strobed sample with the previous strobed sample on that channel. Cycles without smp_valid do not update this history.
- R4: The trigger is the AND of all channel conditions within one strobed sample. A don't-care channel never blocks the trigger.
- R5: A start with every code set to don't care moves the block to capturing on the next cycle. Storing begins with the first strobed sample after that.
- R6: A start with at least one active code sets armed. The sample that satisfies the trigger is the first one stored, and store_en stays low for every sample before it.
- R7: Exactly depth_cfg samples are stored, one for each cycle in which store_en and smp_valid are both high. After the last one, capturing and armed fall, done rises and aborted stays low.
- R8: With two or more edge codes, cfg_err is high and a start pulse is ignored. The block stays idle, stores nothing and keeps its done flag.
- R9: A stop pulse returns the block to idle on the next cycle from any state and sets done and aborted. Stop takes priority over a simultaneous start.
- R10: An accepted start with depth_cfg = 0 sets done on the next cycle without storing any sample.
- R11: An accepted start clears done and aborted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe; smp_data holds a new sample |
| smp_data | input | NUM_CH | Sampled channel levels |
| cond_cfg | input | NUM_CH*3 | Per-channel condition codes |
| depth_cfg | input | DEPTH_W | Number of samples to store |
| start | input | 1 | Start pulse |
| stop | input | 1 | Abort pulse |
| store_en | output | 1 | Current sample goes to storage |
| armed | output | 1 | Waiting for the trigger |
| capturing | output | 1 | Storing samples |
| done | output | 1 | Capture finished or aborted |
| aborted | output | 1 | Last run ended by stop |
| cfg_err | output | 1 | More than one edge condition configured |

## Verification
Level-only conditions are driven with data that satisfies each channel on its own before satisfying both, which tells the AND apart from an OR. An edge paired with a level is driven so that the edge and the level occur in different samples first, which shows that the two must coincide. A rising edge whose high level arrives only during strobe-less cycles separates history updated per strobe from history updated per clock. Free-running captures interleaved with idle strobe cycles, depth 0, two-edge configurations and stops in both the armed and capturing states cover the counting, rejection and abort paths.

// File: rtl/cap_trig_pkg.sv
package cap_trig_pkg;

    localparam int COND_W = 3;

    typedef enum logic [COND_W-1:0] {
        COND_ANY  = 3'd0,
        COND_RISE = 3'd1,
        COND_FALL = 3'd2,
        COND_HIGH = 3'd3,
        COND_LOW  = 3'd4
    } cond_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_CAPTURE = 2'd2
    } cap_state_e;

    function automatic logic cond_is_edge(input logic [COND_W-1:0] c);
        return (c == COND_RISE) || (c == COND_FALL);
    endfunction

    function automatic logic cond_is_active(input logic [COND_W-1:0] c);
        return (c >= COND_RISE) && (c <= COND_LOW);
    endfunction

endpackage

// File: rtl/chan_cond_eval.sv
module chan_cond_eval
    import cap_trig_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic              cur,
    input  logic              hist_ok,
    input  logic [COND_W-1:0] code,
    output logic              match,
    output logic              is_edge,
    output logic              active
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst)            prev_q <= 1'b0;
        else if (smp_valid) prev_q <= cur;
    end

    always_comb begin
        case (code)
            COND_RISE: match = hist_ok && !prev_q && cur;
            COND_FALL: match = hist_ok && prev_q && !cur;
            COND_HIGH: match = cur;
            COND_LOW:  match = !cur;
            default:   match = 1'b1;
        endcase
    end

    assign is_edge = cond_is_edge(code);
    assign active  = cond_is_active(code);

endmodule

// File: rtl/trig_combine.sv
module trig_combine #(
    parameter int NUM_CH = 16
) (
    input  logic [NUM_CH-1:0] match_v,
    input  logic [NUM_CH-1:0] edge_v,
    input  logic [NUM_CH-1:0] active_v,
    output logic              all_match,
    output logic              any_active,
    output logic              multi_edge
);
    localparam int ECW = $clog2(NUM_CH + 1);
    logic [ECW-1:0] n_edges;

    always_comb begin
        n_edges = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            n_edges = n_edges + ECW'(edge_v[i]);
        end
    end

    assign all_match  = &match_v;
    assign any_active = |active_v;
    assign multi_edge = (n_edges > ECW'(1));

endmodule

// File: rtl/depth_counter.sv
module depth_counter #(
    parameter int DEPTH_W = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               inc,
    input  logic [DEPTH_W-1:0] limit,
    output logic [DEPTH_W-1:0] count,
    output logic               last
);
    always_ff @(posedge clk) begin
        if (rst || clr) count <= '0;
        else if (inc)   count <= count + DEPTH_W'(1);
    end

    assign last = (count == limit - DEPTH_W'(1));

endmodule

// File: rtl/capture_trigger_ctrl.sv
module capture_trigger_ctrl
    import cap_trig_pkg::*;
#(
    parameter int NUM_CH  = 16,
    parameter int DEPTH_W = 24
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     smp_valid,
    input  logic [NUM_CH-1:0]        smp_data,
    input  logic [NUM_CH*COND_W-1:0] cond_cfg,
    input  logic [DEPTH_W-1:0]       depth_cfg,
    input  logic                     start,
    input  logic                     stop,
    output logic                     store_en,
    output logic                     armed,
    output logic                     capturing,
    output logic                     done,
    output logic                     aborted,
    output logic                     cfg_err
);
    cap_state_e          state_q;
    logic                done_q, aborted_q, hist_ok_q;
    logic [DEPTH_W-1:0]  depth_q;
    logic [NUM_CH-1:0]   match_v, edge_v, active_v;
    logic                all_match, any_active;
    logic                trig_fire, accept, cnt_last;
    logic [DEPTH_W-1:0]  cnt;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        chan_cond_eval u_eval (
            .clk       (clk),
            .rst       (rst),
            .smp_valid (smp_valid),
            .cur       (smp_data[i]),
            .hist_ok   (hist_ok_q),
            .code      (cond_cfg[i*COND_W +: COND_W]),
            .match     (match_v[i]),
            .is_edge   (edge_v[i]),
            .active    (active_v[i])
        );
    end

    trig_combine #(.NUM_CH(NUM_CH)) u_comb (
        .match_v    (match_v),
        .edge_v     (edge_v),
        .active_v   (active_v),
        .all_match  (all_match),
        .any_active (any_active),
        .multi_edge (cfg_err)
    );

    assign accept    = (state_q == ST_IDLE) && start && !stop && !cfg_err;
    assign trig_fire = (state_q == ST_ARMED) && smp_valid && all_match;
    assign store_en  = !stop && (trig_fire || ((state_q == ST_CAPTURE) && smp_valid));

    depth_counter #(.DEPTH_W(DEPTH_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (accept),
        .inc   (store_en),
        .limit (depth_q),
        .count (cnt),
        .last  (cnt_last)
    );

    always_ff @(posedge clk) begin
        if (rst)            hist_ok_q <= 1'b0;
        else if (smp_valid) hist_ok_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            done_q    <= 1'b0;
            aborted_q <= 1'b0;
            depth_q   <= '0;
        end else if (stop) begin
            state_q   <= ST_IDLE;
            done_q    <= 1'b1;
            aborted_q <= 1'b1;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        aborted_q <= 1'b0;
                        depth_q   <= depth_cfg;
                        if (depth_cfg == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            done_q  <= 1'b0;
                            state_q <= any_active ? ST_ARMED : ST_CAPTURE;
                        end
                    end
                end
                ST_ARMED, ST_CAPTURE: begin
                    if (store_en && cnt_last) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else if (trig_fire) begin
                        state_q <= ST_CAPTURE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign armed     = (state_q == ST_ARMED);
    assign capturing = (state_q == ST_CAPTURE);
    assign done      = done_q;
    assign aborted   = aborted_q;

    AST_STORE_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
        store_en |-> smp_valid);                                        // R7
    AST_IDLE_NO_STORE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> !store_en);                            // R6
    AST_ERR_NO_ARM: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_IDLE) && start && cfg_err) |=> (state_q == ST_IDLE)); // R8
    AST_STOP_ABORTS: assert property (@(posedge clk) disable iff (rst)
        stop |=> ((state_q == ST_IDLE) && done_q && aborted_q));        // R9
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CAPTURE) |-> (cnt < depth_q));                   // R7
    AST_ARM_ON_COND: assert property (@(posedge clk) disable iff (rst)
        (accept && any_active && (depth_cfg != '0)) |=> (state_q == ST_ARMED)); // R6
    AST_ZERO_DEPTH: assert property (@(posedge clk) disable iff (rst)
        (accept && (depth_cfg == '0)) |=> (done_q && (state_q == ST_IDLE)));    // R10

endmodule

// File: tb/tb_capture_trigger_ctrl.sv
`timescale 1ns/1ps
module tb_capture_trigger_ctrl;
    localparam int NCH = 16;
    localparam int DW  = 24;

    logic            clk = 1'b0;
    logic            rst;
    logic            smp_valid;
    logic [NCH-1:0]  smp_data;
    logic [NCH*3-1:0] cond_cfg;
    logic [DW-1:0]   depth_cfg;
    logic            start, stop;
    logic            store_en, armed, capturing, done, aborted, cfg_err;

    int n_tests = 0, n_fail = 0;
    int n_store, first_idx, idx;

    capture_trigger_ctrl #(.NUM_CH(NCH), .DEPTH_W(DW)) dut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .cond_cfg(cond_cfg), .depth_cfg(depth_cfg), .start(start), .stop(stop),
        .store_en(store_en), .armed(armed), .capturing(capturing), .done(done),
        .aborted(aborted), .cfg_err(cfg_err)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_cond(input int ch, input logic [2:0] code);
        cond_cfg[ch*3 +: 3] = code;
    endtask

    task automatic begin_run();
        n_store = 0; first_idx = -1; idx = 0;
    endtask

    task automatic step(input logic v, input logic [NCH-1:0] d);
        @(negedge clk);
        start = 0; stop = 0; smp_valid = v; smp_data = d;
        #1;
        if (store_en) begin
            n_store++;
            if (first_idx < 0) first_idx = idx;
        end
        idx++;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1; stop = 0; smp_valid = 0;
        @(negedge clk);
        start = 0;
        #1;
    endtask

    task automatic pulse_stop();
        @(negedge clk);
        stop = 1; start = 0; smp_valid = 0;
        @(negedge clk);
        stop = 0;
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, '0);
    endtask

    task automatic t_reset();
        chk("R1 armed", armed, 0);
        chk("R1 capturing", capturing, 0);
        chk("R1 done", done, 0);
        chk("R1 aborted", aborted, 0);
        chk("R1 store_en", store_en, 0);
    endtask

    task automatic t_free_run();
        cond_cfg = '0; depth_cfg = 4;
        pulse_start();
        chk("R5 capturing after start", capturing, 1);
        chk("R5 not armed", armed, 0);
        begin_run();
        step(1, 16'h1); step(0, 16'h2); step(1, 16'h3); step(0, 16'h4);
        step(1, 16'h5); step(1, 16'h6); step(1, 16'h7); step(1, 16'h8);
        chk("R5 first store index", first_idx, 0);
        chk("R7 stored count", n_store, 4);
        idle(1);
        chk("R7 done", done, 1);
        chk("R7 aborted low", aborted, 0);
        chk("R7 capturing low", capturing, 0);
    endtask

    task automatic t_level_and();
        cond_cfg = '0; set_cond(0, 3'd3); set_cond(1, 3'd4); depth_cfg = 3;
        pulse_start();
        chk("R6 armed", armed, 1);
        chk("R11 done cleared", done, 0);
        begin_run();
        step(1, 16'h3); step(1, 16'h0); step(1, 16'h1);
        step(1, 16'h3); step(1, 16'h3); step(1, 16'h1);
        chk("R4 level AND first store", first_idx, 2);
        chk("R7 level stored count", n_store, 3);
    endtask

    task automatic t_rise_level();
        cond_cfg = '0; set_cond(2, 3'd1); set_cond(3, 3'd3); depth_cfg = 2;
        pulse_start();
        begin_run();
        step(1, 16'h0); step(1, 16'h4); step(1, 16'hC); step(1, 16'h8);
        step(1, 16'hC); step(1, 16'h0); step(1, 16'h0);
        chk("R4 edge and level coincide", first_idx, 4);
        chk("R2 rise stored count", n_store, 2);
    endtask

    task automatic t_strobe_history();
        cond_cfg = '0; set_cond(5, 3'd1); depth_cfg = 1;
        pulse_start();
        begin_run();
        step(1, 16'h0); step(0, 16'h20); step(0, 16'h20);
        chk("R3 no store on unstrobed data", n_store, 0);
        step(1, 16'h20); step(1, 16'h0);
        chk("R3 edge against last strobed sample", first_idx, 3);
        chk("R7 depth one count", n_store, 1);
    endtask

    task automatic t_fall_reserved();
        cond_cfg = '0; set_cond(7, 3'd2); set_cond(8, 3'd6); depth_cfg = 1;
        pulse_start();
        begin_run();
        step(1, 16'h80); step(1, 16'h80); step(1, 16'h0); step(1, 16'h0);
        chk("R2 fall with reserved code first store", first_idx, 2);
        chk("R2 fall stored count", n_store, 1);
    endtask

    task automatic t_cfg_err();
        cond_cfg = '0; set_cond(0, 3'd1); set_cond(1, 3'd2); depth_cfg = 2;
        #1;
        chk("R8 cfg_err", cfg_err, 1);
        pulse_start();
        chk("R8 not armed", armed, 0);
        chk("R8 not capturing", capturing, 0);
        chk("R8 done kept", done, 1);
        begin_run();
        step(1, 16'h0); step(1, 16'h1); step(1, 16'h2); step(1, 16'h0);
        chk("R8 nothing stored", n_store, 0);
    endtask

    task automatic t_stop();
        cond_cfg = '0; set_cond(0, 3'd3); depth_cfg = 2;
        pulse_start();
        chk("R6 armed before stop", armed, 1);
        pulse_stop();
        chk("R9 armed low after stop", armed, 0);
        chk("R9 done", done, 1);
        chk("R9 aborted", aborted, 1);
        cond_cfg = '0; depth_cfg = 10;
        pulse_start();
        chk("R11 aborted cleared", aborted, 0);
        chk("R11 done cleared", done, 0);
        begin_run();
        step(1, 16'h1); step(1, 16'h2); step(1, 16'h3);
        pulse_stop();
        step(1, 16'h4); step(1, 16'h5); step(1, 16'h6);
        chk("R9 stores stop at abort", n_store, 3);
        chk("R9 aborted in capture", aborted, 1);
        chk("R9 capturing low", capturing, 0);
        @(negedge clk);
        start = 1; stop = 1;
        @(negedge clk);
        start = 0; stop = 0;
        #1;
        chk("R9 stop beats start", capturing, 0);
        chk("R9 aborted with start", aborted, 1);
    endtask

    task automatic t_zero_depth();
        cond_cfg = '0; depth_cfg = 0;
        pulse_start();
        chk("R10 done at once", done, 1);
        chk("R10 not capturing", capturing, 0);
        chk("R10 not aborted", aborted, 0);
        begin_run();
        step(1, 16'h1); step(1, 16'h2);
        chk("R10 nothing stored", n_store, 0);
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1; smp_valid = 0; smp_data = '0; cond_cfg = '0;
        depth_cfg = '0; start = 0; stop = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        t_reset();
        t_free_run();
        t_level_and();
        t_rise_level();
        t_strobe_history();
        t_fall_reserved();
        t_cfg_err();
        t_stop();
        t_zero_depth();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule